// File: doc/BRIEF.md
# Dual-Mode Burst Address Generator

This block sits in front of a synchronous burst memory array and supplies the address for every access in a four-beat burst. When a burst opens, it captures the whole external address. On each later beat it works out the next in-burst address from the two captured low bits. The upper bits stay as captured for the whole burst.

A burst can be opened by either of two strobes, one from the processor side and one from the controller side. The processor-side strobe only counts while the first chip select is asserted. A static mode input chooses the beat order. In linear order the low bits count up modulo four from the starting offset. In interleaved order each beat's low bits are the starting offset XOR the beat number.

An advance strobe steps the burst by one beat. While the advance strobe is inactive, the address is held, which suspends the burst. All control inputs are active low and are sampled on the rising clock edge.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset the beat index is 0 and the output address is 0, and no burst is open.
- R2: A processor start (start_cpu_n low while sel_n is low) captures ext_addr. On the following cycle cur_addr equals the captured address and beat is 0.
- R3: A processor start while sel_n is high is blocked: neither the address nor the beat changes.
- R4: A controller start (start_ctl_n low) captures ext_addr and clears beat whatever the level of sel_n.
- R5: With seq_xor low (linear order), the low two bits of cur_addr equal (captured low bits + beat) mod 4, for example 1,2,3,0.
- R6: With seq_xor high (interleaved order), the low two bits of cur_addr equal the captured low bits XOR beat, for example 2,3,0,1.
- R7: Bits AW-1 down to 2 of cur_addr keep their captured value until the next start.
- R8: In an open burst with no start, adv_n sampled low increments beat modulo 4, and adv_n sampled high holds beat.
- R9: adv_n is ignored on the edge where a processor start loads: beat is 0 afterwards even if adv_n was low.
- R10: After the fourth beat the beat index wraps to 0, and cur_addr returns to the captured start address.
- R11: adv_n has no effect before the first start after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_addr | input | AW | External address captured at a start |
| start_cpu_n | input | 1 | Processor-side burst start, active low, qualified by sel_n |
| start_ctl_n | input | 1 | Controller-side burst start, active low, unqualified |
| adv_n | input | 1 | Advance one beat, active low |
| sel_n | input | 1 | First chip select, active low; gates start_cpu_n only |
| seq_xor | input | 1 | Beat order: 0 linear, 1 interleaved |
| cur_addr | output | AW | Current array address |
| beat | output | 2 | Beat index within the burst |

## Verification
The hardest situations to reach are the edges where several strobes meet. These are a processor start together with an active advance, a processor start that the chip select blocks while an advance is pending, and a controller start that cuts into a burst already under way. The stimulus drives each of these combinations on purpose, partway through bursts that began at non-zero offsets. It also runs a long suspended burst across the wrap, in both orders. A behavioural model compares the address and the beat on every cycle.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ext_addr,
  input  logic          start_cpu_n,
  input  logic          start_ctl_n,
  input  logic          adv_n,
  input  logic          sel_n,
  input  logic          seq_xor,
  output logic [AW-1:0] cur_addr,
  output logic [1:0]    beat
);

  logic [AW-1:0] base_q;
  logic [1:0]    beat_q;
  logic          open_q;
  logic          load;
  logic          step;
  logic [1:0]    low;

  assign load = (!start_cpu_n && !sel_n) || !start_ctl_n;
  assign step = open_q && !load && !adv_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= 2'd0;
      open_q <= 1'b0;
    end else if (load) begin
      base_q <= ext_addr;
      beat_q <= 2'd0;
      open_q <= 1'b1;
    end else if (step) begin
      beat_q <= beat_q + 2'd1;
    end
  end

  assign low      = seq_xor ? (base_q[1:0] ^ beat_q) : (base_q[1:0] + beat_q);
  assign cur_addr = {base_q[AW-1:2], low};
  assign beat     = beat_q;

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] ext_addr,
  input logic          start_cpu_n,
  input logic          start_ctl_n,
  input logic          adv_n,
  input logic          sel_n,
  input logic          seq_xor,
  input logic [AW-1:0] cur_addr,
  input logic [1:0]    beat
);

  logic       st;
  logic       seen;
  logic [1:0] org;

  assign st = (!start_cpu_n && !sel_n) || !start_ctl_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= 1'b0;
      org  <= 2'd0;
    end else if (st) begin
      seen <= 1'b1;
      org  <= ext_addr[1:0];
    end
  end

  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    st |=> (beat == 2'd0) && (cur_addr[AW-1:2] == $past(ext_addr[AW-1:2]))); // R2
  AST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n && start_ctl_n && adv_n) |=> $stable(beat) && $stable(cur_addr[AW-1:2])); // R3
  AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !st |=> $stable(cur_addr[AW-1:2])); // R7
  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !st && !adv_n) |=> beat == $past(beat) + 2'd1); // R8
  AST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> beat == 2'd0); // R11
  AST_LIN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !seq_xor) |-> cur_addr[1:0] == org + beat); // R5
  AST_XOR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && seq_xor) |-> cur_addr[1:0] == (org ^ beat)); // R6

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .start_cpu_n(start_cpu_n),
  .start_ctl_n(start_ctl_n), .adv_n(adv_n), .sel_n(sel_n), .seq_xor(seq_xor),
  .cur_addr(cur_addr), .beat(beat)
);

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;
  localparam int AW = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic start_cpu_n = 1'b1, start_ctl_n = 1'b1, adv_n = 1'b1, sel_n = 1'b1, seq_xor = 1'b0;
  logic [AW-1:0] cur_addr;
  logic [1:0] beat;

  int errors = 0;
  int checks = 0;
  string tag = "R1";

  int m_base = 0, m_beat = 0;
  bit m_open = 0;

  always #4 clk = ~clk;

  burst_addr_gen #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .start_cpu_n(start_cpu_n),
    .start_ctl_n(start_ctl_n), .adv_n(adv_n), .sel_n(sel_n), .seq_xor(seq_xor),
    .cur_addr(cur_addr), .beat(beat)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_base = 0; m_beat = 0; m_open = 0;
    end else if ((!start_cpu_n && !sel_n) || !start_ctl_n) begin
      m_base = int'(ext_addr); m_beat = 0; m_open = 1;
    end else if (m_open && !adv_n) begin
      m_beat = (m_beat + 1) % 4;
    end
  end

  function automatic int model_addr();
    int lo;
    lo = seq_xor ? ((m_base % 4) ^ m_beat) : (((m_base % 4) + m_beat) % 4);
    return (m_base / 4) * 4 + lo;
  endfunction

  task automatic check(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check(int'(cur_addr), model_addr(), "model addr");
    check(int'(beat), m_beat, "model beat");
  end

  task automatic tick(input bit cpu, input bit ctl, input bit adv, input bit sel, input int a);
    start_cpu_n = cpu; start_ctl_n = ctl; adv_n = adv; sel_n = sel; ext_addr = AW'(a);
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic idle(input bit adv);
    tick(1'b1, 1'b1, adv, 1'b1, 20'h0);
  endtask

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    tag = "R1";
    check(int'(beat), 0, "reset beat");
    check(int'(cur_addr), 0, "reset addr");
    tag = "R11";
    idle(1'b0); idle(1'b0);
    check(int'(beat), 0, "adv before start");

    tag = "R9";
    seq_xor = 1'b0;
    tick(1'b0, 1'b1, 1'b0, 1'b0, 20'hABCD1);
    check(int'(cur_addr), 20'hABCD1, "R2 load addr");
    check(int'(beat), 0, "adv on cpu start");
    tag = "R5";
    idle(1'b0); check(int'(cur_addr[1:0]), 2, "lin beat1");
    idle(1'b0); check(int'(cur_addr[1:0]), 3, "lin beat2");
    tag = "R8";
    idle(1'b1); check(int'(cur_addr[1:0]), 3, "suspend");
    idle(1'b1); check(int'(beat), 2, "suspend beat");
    tag = "R5";
    idle(1'b0); check(int'(cur_addr[1:0]), 0, "lin beat3");
    check(int'(cur_addr[AW-1:2]), 20'hABCD1 >> 2, "R7 upper");
    tag = "R10";
    idle(1'b0); check(int'(cur_addr), 20'hABCD1, "wrap to start");

    tag = "R3";
    tick(1'b0, 1'b1, 1'b1, 1'b1, 20'h12340);
    check(int'(cur_addr), 20'hABCD1, "blocked start");
    tick(1'b0, 1'b1, 1'b0, 1'b1, 20'h12340);
    check(int'(beat), 1, "blocked start with adv");

    tag = "R4";
    seq_xor = 1'b1;
    tick(1'b1, 1'b0, 1'b1, 1'b1, 20'h55552);
    check(int'(cur_addr), 20'h55552, "ctl start sel high");
    tag = "R6";
    idle(1'b0); check(int'(cur_addr[1:0]), 3, "xor beat1");
    idle(1'b0); check(int'(cur_addr[1:0]), 0, "xor beat2");
    idle(1'b0); check(int'(cur_addr[1:0]), 1, "xor beat3");
    tag = "R10";
    idle(1'b0); check(int'(cur_addr), 20'h55552, "xor wrap");

    tag = "R6";
    tick(1'b0, 1'b1, 1'b0, 1'b0, 20'h0F0F3);
    idle(1'b0); check(int'(cur_addr[1:0]), 2, "xor from 3");
    tag = "R4";
    tick(1'b1, 1'b0, 1'b0, 1'b0, 20'h00001);
    check(int'(beat), 0, "ctl restart mid burst");
    check(int'(cur_addr), 20'h00001, "ctl restart addr");

    tag = "R8";
    for (int i = 0; i < 40; i++) begin
      seq_xor = i[4];
      if (i % 9 == 0) tick(1'b0, 1'b1, i[0], i[1], i * 20'h111);
      else idle(i[1] ^ i[0]);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule